// File: doc/BRIEF.md
# Interval Slowdown Estimator

This block tracks one application running on a shared cache and memory system. It reports how much that application is being slowed down by the other applications. Time is cut into intervals of a fixed length. During each interval the block counts events that arrive as per-cycle strobes:
- cache accesses;
- cycles in which the application owns top priority at the memory controller;
- misses sent out and misses returned;
- cycles in which the application waits behind a request that the scheduler just picked for someone else.

A contention-miss count from a shadow tag store is sampled in the last cycle of each interval.

At the end of an interval the counters are frozen and cleared. A small sequencer then runs two divisions on one shared restoring divider. The first division finds the average miss service time seen during top-priority cycles. The second finds the ratio of two access rates:
- the estimated alone access rate: top-priority accesses divided by the corrected top-priority cycle count;
- the measured shared access rate: all accesses divided by the interval length.

The result is published as an unsigned Q8.8 value together with a one-cycle valid strobe. A stale flag is raised when the interval holds too little information for an estimate. In that case the previous value is kept.

Top module: `slowdown_estimator`

## Requirements
- R1: After reset, `slowdown_o` is 0x0100 (1.0), and `valid_o` and `stale_o` are 0.
- R2: An interval lasts INTERVAL_LEN cycles, with the first interval starting at the first clock edge after reset is released. Each interval produces exactly one `valid_o` pulse, one cycle wide, and it arrives before the next interval ends.
- R3: The shared count A is the number of cycles in the interval with `acc_i` high, the last cycle included. Every count restarts from zero in the next interval.
- R4: The top-priority count H is the number of cycles with `hp_owner_i` high. The top-priority access count B is the number of cycles with both `acc_i` and `hp_owner_i` high.
- R5: The outstanding miss count goes up by one for each `miss_issue_i` and down by one for each `miss_return_i`. It is not cleared at interval ends. The latency sum adds the outstanding count, as it stood at the start of the cycle, in every top-priority cycle. M counts the cycles with `miss_return_i` and `hp_owner_i` both high. The average miss service time T is floor(latency sum / M), or 0 when M is 0.
- R6: The contention cycle count is C × T. Here C is the value on `cont_miss_i` in the last cycle of the interval.
- R7: A queueing cycle is a top-priority cycle with a nonzero outstanding count at the start of the cycle and `other_last_i` high. Q is the number of such cycles.
- R8: Let K = H − Q − C×T. The published value is floor(B × INTERVAL_LEN × 256 / (A × K)).
- R9: The published value is clamped to at least 0x0100 and at most 0xFFFF.
- R10: If B is 0 or K ≤ 0, the valid pulse carries `stale_o` = 1 and the previous value of `slowdown_o`. Otherwise it carries `stale_o` = 0. Both outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 1 | Cache access this cycle |
| hp_owner_i | input | 1 | Application holds top memory priority this cycle |
| miss_issue_i | input | 1 | A miss is sent to memory this cycle |
| miss_return_i | input | 1 | A miss returns this cycle |
| other_last_i | input | 1 | Last scheduled memory request belonged to another application |
| cont_miss_i | input | CMISS_W | Contention-miss count from the shadow tag store |
| slowdown_o | output | 16 | Slowdown estimate, unsigned Q8.8 |
| valid_o | output | 1 | One-cycle strobe with each new estimate |
| stale_o | output | 1 | Last estimate was held for lack of data |

## Verification
The bench counts the events itself and predicts every published value with integer arithmetic. It targets several corner cases:
- Intervals with no top-priority access must hold the old value and mark it stale. A design that divides anyway would publish garbage.
- Contention counts large enough that K drops to zero or below must also give a stale pulse. A design that gets this wrong would wrap around to a huge divisor.
- Intervals where the alone rate is lower than the shared rate must clamp the output to 1.0.
- Events in the last cycle of an interval must be counted, and outstanding misses must carry across interval ends. A design that got either wrong would drift by one count and publish a value that differs from the prediction.

// File: rtl/isd_pkg.sv
package isd_pkg;
    localparam int Q_FRAC = 8;
    localparam int Q_W    = 16;
    localparam logic [Q_W-1:0] Q_ONE = 16'h0100;
    localparam logic [Q_W-1:0] Q_MAX = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AVG,
        ST_CHK,
        ST_RAT
    } est_state_e;
endpackage

// File: rtl/isd_accum.sv
module isd_accum #(
    parameter int INTERVAL_LEN = 64,
    parameter int OUT_W        = 4,
    parameter int CNT_W        = $clog2(INTERVAL_LEN + 1),
    parameter int LAT_W        = CNT_W + OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             hp_i,
    input  logic             iss_i,
    input  logic             ret_i,
    input  logic             oth_i,
    input  logic [CNT_W-1:0] cmiss_i,
    output logic             tick_o,
    output logic             snap_v_o,
    output logic [CNT_W-1:0] s_all_o,
    output logic [CNT_W-1:0] s_hpacc_o,
    output logic [CNT_W-1:0] s_hpcyc_o,
    output logic [CNT_W-1:0] s_qcyc_o,
    output logic [CNT_W-1:0] s_mret_o,
    output logic [CNT_W-1:0] s_cmiss_o,
    output logic [LAT_W-1:0] s_lat_o
);
    typedef struct packed {
        logic [CNT_W-1:0] icnt;
        logic [CNT_W-1:0] n_all;
        logic [CNT_W-1:0] n_hpacc;
        logic [CNT_W-1:0] n_hpcyc;
        logic [CNT_W-1:0] n_qcyc;
        logic [CNT_W-1:0] n_mret;
        logic [LAT_W-1:0] n_lat;
        logic [OUT_W-1:0] outst;
        logic [CNT_W-1:0] s_all;
        logic [CNT_W-1:0] s_hpacc;
        logic [CNT_W-1:0] s_hpcyc;
        logic [CNT_W-1:0] s_qcyc;
        logic [CNT_W-1:0] s_mret;
        logic [CNT_W-1:0] s_cmiss;
        logic [LAT_W-1:0] s_lat;
        logic             snap_v;
    } acc_st_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_LEN - 1);

    acc_st_t st_d, st_q;
    logic    tick;

    assign tick = (st_q.icnt == LAST);

    always_comb begin
        st_d        = st_q;
        st_d.snap_v = 1'b0;
        if (acc_i) st_d.n_all = st_q.n_all + 1'b1;
        if (hp_i) begin
            st_d.n_hpcyc = st_q.n_hpcyc + 1'b1;
            st_d.n_lat   = st_q.n_lat + LAT_W'(st_q.outst);
            if (acc_i) st_d.n_hpacc = st_q.n_hpacc + 1'b1;
            if (ret_i) st_d.n_mret  = st_q.n_mret + 1'b1;
            if (oth_i && (st_q.outst != '0)) st_d.n_qcyc = st_q.n_qcyc + 1'b1;
        end
        st_d.outst = st_q.outst + OUT_W'(iss_i) - OUT_W'(ret_i);
        if (tick) begin
            st_d.s_all   = st_d.n_all;
            st_d.s_hpacc = st_d.n_hpacc;
            st_d.s_hpcyc = st_d.n_hpcyc;
            st_d.s_qcyc  = st_d.n_qcyc;
            st_d.s_mret  = st_d.n_mret;
            st_d.s_lat   = st_d.n_lat;
            st_d.s_cmiss = cmiss_i;
            st_d.snap_v  = 1'b1;
            st_d.icnt    = '0;
            st_d.n_all   = '0;
            st_d.n_hpacc = '0;
            st_d.n_hpcyc = '0;
            st_d.n_qcyc  = '0;
            st_d.n_mret  = '0;
            st_d.n_lat   = '0;
        end else begin
            st_d.icnt = st_q.icnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o    = tick;
    assign snap_v_o  = st_q.snap_v;
    assign s_all_o   = st_q.s_all;
    assign s_hpacc_o = st_q.s_hpacc;
    assign s_hpcyc_o = st_q.s_hpcyc;
    assign s_qcyc_o  = st_q.s_qcyc;
    assign s_mret_o  = st_q.s_mret;
    assign s_cmiss_o = st_q.s_cmiss;
    assign s_lat_o   = st_q.s_lat;
endmodule

// File: rtl/isd_divider.sv
module isd_divider #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] step;
        logic [W-1:0]  quo;
        logic [W:0]    rem;
        logic [W-1:0]  dsr;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0] rem_sh;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem_sh    = {st_q.rem[W-1:0], st_q.quo[W-1]};
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.quo  = dividend_i;
            st_d.rem  = '0;
            st_d.dsr  = divisor_i;
        end else if (st_q.busy) begin
            if (rem_sh >= {1'b0, st_q.dsr}) begin
                st_d.rem = rem_sh - {1'b0, st_q.dsr};
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = rem_sh;
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign quot_o = st_q.quo;
endmodule

// File: rtl/slowdown_estimator.sv
module slowdown_estimator
    import isd_pkg::*;
#(
    parameter int INTERVAL_LEN = 64,
    parameter int OUT_W        = 4,
    parameter int CMISS_W      = $clog2(INTERVAL_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_i,
    input  logic               hp_owner_i,
    input  logic               miss_issue_i,
    input  logic               miss_return_i,
    input  logic               other_last_i,
    input  logic [CMISS_W-1:0] cont_miss_i,
    output logic [Q_W-1:0]     slowdown_o,
    output logic               valid_o,
    output logic               stale_o
);
    localparam int CNT_W  = CMISS_W;
    localparam int LAT_W  = CNT_W + OUT_W;
    localparam int NUM_W  = 2 * CNT_W + Q_FRAC;
    localparam int DW     = (NUM_W > LAT_W) ? NUM_W : LAT_W;
    localparam int CONT_W = CNT_W + LAT_W;

    typedef struct packed {
        est_state_e       st;
        logic [CNT_W-1:0] all;
        logic [CNT_W-1:0] hpacc;
        logic [CNT_W-1:0] hpcyc;
        logic [CNT_W-1:0] qcyc;
        logic [CNT_W-1:0] mret;
        logic [CNT_W-1:0] cmiss;
        logic [LAT_W-1:0] avg;
        logic [Q_W-1:0]   sd;
        logic             vld;
        logic             stale;
    } est_st_t;

    logic             tick, snap_v;
    logic [CNT_W-1:0] s_all, s_hpacc, s_hpcyc, s_qcyc, s_mret, s_cmiss;
    logic [LAT_W-1:0] s_lat;
    logic             div_start, div_done;
    logic [DW-1:0]    div_n, div_d, div_q;
    logic [CONT_W-1:0] cont;
    logic [CNT_W-1:0]  sub;
    logic [CNT_W-1:0]  corr;
    logic              eng_idle;

    est_st_t cur, nxt;

    isd_accum #(
        .INTERVAL_LEN(INTERVAL_LEN),
        .OUT_W       (OUT_W),
        .CNT_W       (CNT_W),
        .LAT_W       (LAT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (acc_i),
        .hp_i     (hp_owner_i),
        .iss_i    (miss_issue_i),
        .ret_i    (miss_return_i),
        .oth_i    (other_last_i),
        .cmiss_i  (cont_miss_i),
        .tick_o   (tick),
        .snap_v_o (snap_v),
        .s_all_o  (s_all),
        .s_hpacc_o(s_hpacc),
        .s_hpcyc_o(s_hpcyc),
        .s_qcyc_o (s_qcyc),
        .s_mret_o (s_mret),
        .s_cmiss_o(s_cmiss),
        .s_lat_o  (s_lat)
    );

    isd_divider #(.W(DW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(div_n),
        .divisor_i (div_d),
        .done_o    (div_done),
        .quot_o    (div_q)
    );

    assign cont = CONT_W'(cur.cmiss) * CONT_W'(cur.avg);
    assign sub  = cur.hpcyc - cur.qcyc;
    assign corr = sub - cont[CNT_W-1:0];

    always_comb begin
        nxt       = cur;
        nxt.vld   = 1'b0;
        div_start = 1'b0;
        div_n     = '0;
        div_d     = '0;
        unique case (cur.st)
            ST_IDLE: begin
                if (snap_v) begin
                    nxt.all   = s_all;
                    nxt.hpacc = s_hpacc;
                    nxt.hpcyc = s_hpcyc;
                    nxt.qcyc  = s_qcyc;
                    nxt.mret  = s_mret;
                    nxt.cmiss = s_cmiss;
                    div_start = 1'b1;
                    div_n     = DW'(s_lat);
                    div_d     = DW'(s_mret);
                    nxt.st    = ST_AVG;
                end
            end
            ST_AVG: begin
                if (div_done) begin
                    nxt.avg = (cur.mret == '0) ? '0 : div_q[LAT_W-1:0];
                    nxt.st  = ST_CHK;
                end
            end
            ST_CHK: begin
                if ((cur.hpacc == '0) || (cont >= CONT_W'(sub))) begin
                    nxt.vld   = 1'b1;
                    nxt.stale = 1'b1;
                    nxt.st    = ST_IDLE;
                end else begin
                    div_start = 1'b1;
                    div_n     = (DW'(cur.hpacc) * DW'(INTERVAL_LEN)) << Q_FRAC;
                    div_d     = DW'(cur.all) * DW'(corr);
                    nxt.st    = ST_RAT;
                end
            end
            ST_RAT: begin
                if (div_done) begin
                    if (div_q < DW'(Q_ONE))      nxt.sd = Q_ONE;
                    else if (div_q > DW'(Q_MAX)) nxt.sd = Q_MAX;
                    else                         nxt.sd = div_q[Q_W-1:0];
                    nxt.vld   = 1'b1;
                    nxt.stale = 1'b0;
                    nxt.st    = ST_IDLE;
                end
            end
            default: nxt.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            cur.st    <= ST_IDLE;
            cur.sd    <= Q_ONE;
        end else begin
            cur <= nxt;
        end
    end

    assign eng_idle   = (cur.st == ST_IDLE);
    assign slowdown_o = cur.sd;
    assign valid_o    = cur.vld;
    assign stale_o    = cur.stale;
endmodule

// File: rtl/isd_checker.sv
module isd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        eng_idle,
    input logic        valid_o,
    input logic        stale_o,
    input logic [15:0] slowdown_o
);
    // R2: strobe is one cycle wide
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2: previous estimate finished before the next interval closes
    a_r2_done_before_next: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> eng_idle);

    // R9: fresh estimate never below 1.0
    a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !stale_o) |-> (slowdown_o >= 16'h0100));

    // R10: stale pulse keeps the old value
    a_r10_stale_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stale_o) |-> (slowdown_o == $past(slowdown_o)));

    // R10: outputs quiet between pulses
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(slowdown_o) && $stable(stale_o)));
endmodule

bind slowdown_estimator isd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .eng_idle  (eng_idle),
    .valid_o   (valid_o),
    .stale_o   (stale_o),
    .slowdown_o(slowdown_o)
);

// File: tb/slowdown_estimator_tb.sv
module slowdown_estimator_tb;
    localparam int L   = 64;
    localparam int CMW = $clog2(L + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc = 0, hp = 0, iss = 0, ret = 0, oth = 0;
    logic [CMW-1:0] cm = '0;
    logic [15:0] sd;
    logic vld, stl;

    always #5 clk = ~clk;

    slowdown_estimator #(.INTERVAL_LEN(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .hp_owner_i(hp),
        .miss_issue_i(iss), .miss_return_i(ret), .other_last_i(oth),
        .cont_miss_i(cm), .slowdown_o(sd), .valid_o(vld), .stale_o(stl)
    );

    int checks = 0, fails = 0, n_iv = 0, n_vld = 0;
    longint exp_sd[$];
    bit     exp_st[$];
    longint prev_sd = 256;
    longint m_all, m_hpacc, m_hpcyc, m_q, m_mret, m_lat, outs = 0;
    bit prev_vld = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exv);
        end
    endtask

    // monitor: compare each pulse with the arithmetic prediction
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(vld && prev_vld), "R2 pulse width", 2, 1);
            if (vld) begin
                n_vld++;
                if (exp_sd.size() == 0) chk(0, "R2 unexpected pulse", 1, 0);
                else begin
                    longint e; bit es;
                    e = exp_sd.pop_front(); es = exp_st.pop_front();
                    chk(sd == e, "R8 R9 slowdown", sd, e);
                    chk(stl == es, "R10 stale flag", stl, es);
                end
            end
            prev_vld = vld;
        end
    end

    task automatic cyc(input bit a, input bit h, input bit i, input bit r, input bit o);
        acc = a; hp = h; iss = i; ret = r; oth = o;
        if (a) m_all++;
        if (h) begin
            m_hpcyc++;
            m_lat += outs;
            if (a) m_hpacc++;
            if (r) m_mret++;
            if (o && outs != 0) m_q++;
        end
        outs = outs + i - r;
        @(negedge clk);
    endtask

    // one interval; probabilities in eighths
    task automatic run_iv(input int pa_hp, input int pa_lo, input int ph, input bit half,
                          input int pm, input int po, input int cmv);
        longint avg, cont, sub, q;
        m_all = 0; m_hpacc = 0; m_hpcyc = 0; m_q = 0; m_mret = 0; m_lat = 0;
        cm = CMW'(cmv);
        for (int c = 0; c < L; c++) begin
            bit h, a, i, r;
            h = half ? (c < L/2) : ($urandom_range(0,7) < ph);
            a = $urandom_range(0,7) < (h ? pa_hp : pa_lo);
            i = (outs < 15) && ($urandom_range(0,7) < pm);
            r = (outs > 0) && ($urandom_range(0,7) < pm);
            cyc(a, h, i, r, $urandom_range(0,7) < po);
        end
        n_iv++;
        // R5 R6 R7: average service time, contention, queueing
        avg  = (m_mret == 0) ? 0 : m_lat / m_mret;
        cont = longint'(cmv) * avg;
        sub  = m_hpcyc - m_q;
        if (m_hpacc == 0 || cont >= sub) begin
            exp_sd.push_back(prev_sd); exp_st.push_back(1'b1);
        end else begin
            q = (m_hpacc * L * 256) / (m_all * (sub - cont));
            if (q < 256) q = 256;
            if (q > 65535) q = 65535;
            prev_sd = q;
            exp_sd.push_back(q); exp_st.push_back(1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sd == 16'h0100, "R1 reset value", sd, 256);
        chk(vld == 0, "R1 reset valid", vld, 0);
        chk(stl == 0, "R1 reset stale", stl, 0);
        rst_n = 1'b1;
        // R10: nothing at all -> stale, keep 1.0
        run_iv(0, 0, 0, 0, 0, 0, 0);
        // R8: always top priority, access each cycle -> exactly 1.0
        run_iv(8, 8, 8, 0, 0, 0, 0);
        // R4 R8: priority first half, accesses only there -> 2.0
        run_iv(8, 0, 0, 1, 0, 0, 0);
        // R6 R10: heavy contention pushes K to or below zero
        run_iv(8, 8, 8, 0, 6, 0, 63);
        // R9: alone rate below shared rate -> clamp to 1.0
        run_iv(1, 8, 0, 1, 0, 0, 0);
        // R5 R7: queueing and miss traffic, every density mix
        for (int pa = 1; pa <= 8; pa += 3)
            for (int ph = 1; ph <= 8; ph += 2)
                for (int pm = 0; pm <= 6; pm += 3)
                    for (int po = 0; po <= 8; po += 4)
                        run_iv(pa, 8 - pa + 1, ph, 0, pm, po, $urandom_range(0, 3));
        // R3: back-to-back random intervals, counters restart each time
        for (int k = 0; k < 60; k++)
            run_iv($urandom_range(0,8), $urandom_range(0,8), $urandom_range(0,8),
                   0, $urandom_range(0,7), $urandom_range(0,8), $urandom_range(0,6));
        acc = 0; hp = 0; iss = 0; ret = 0; oth = 0;
        repeat (L - 6) @(negedge clk);
        chk(n_vld == n_iv, "R2 pulse count", n_vld, n_iv);
        chk(exp_sd.size() == 0, "R2 missing pulses", exp_sd.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", n_vld, n_iv);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule